// File: doc/BRIEF.md
# Delay-feedback NTT butterfly stage

This block is one radix-2 decimation-in-frequency butterfly stage for a number theoretic transform over a prime modulus `Q`. It takes one residue per clock from the previous stage and sends at most one residue per clock to the next stage. A feedback FIFO holds half of the current block, so only one value enters the butterfly each cycle. Stages of this kind can be chained in series. Because the FIFO length is chosen at run time, the same hardware can serve different transform stages over several passes.

Each block runs through three phases, and each phase lasts `L` steps. In the fill phase, incoming values are stored. In the compute phase, each stored value `a` is paired with the incoming value `b`: the sum goes forward and the twiddled difference goes back into the FIFO. In the drain phase, the stored differences are sent out, one per cycle. During the drain, any new input is stored as the first half of the next block. An outside controller supplies the twiddle factor in the same cycle that a strobe asks for it. When the FIFO is empty, a bypass control turns the stage into a plain one-cycle pass-through. This serves leftover stages of a pass.

Top module: `ntt_sdf_stage`

## Requirements
- R1: While reset is high and right after it, `out_valid` and `tw_req` are 0 and the FIFO is empty.
- R2: In the fill phase, each accepted input (`in_valid`=1) is stored and produces no output. After `L` accepted inputs the stage enters the compute phase.
- R3: In the compute phase, the k-th accepted input `b` is paired with the k-th stored value `a`. One cycle later the output is `(a+b) mod Q` with `out_valid`=1.
- R4: In the same compute step, `((a-b)*w) mod Q` is stored, where `w` is `tw_data` in that cycle. These results are sent out later in the order they were stored.
- R5: The drain phase lasts exactly `L` consecutive cycles after the last compute step. It emits one stored result per cycle whether or not `in_valid` is high.
- R6: Inputs accepted during the drain are stored as the first half of the next block. If `L` inputs arrived during the drain, the next phase is compute; otherwise it is fill, continuing from the count already stored.
- R7: The fill and compute phases advance only on cycles with `in_valid`=1. Cycles without `in_valid` in these phases give `out_valid`=0 and change nothing.
- R8: `tw_req` is 1 in exactly the cycles in which the stage is in the compute phase.
- R9: `L = 2^cfg_log_len`, and values above `LOG_LMAX` are clamped to `LOG_LMAX`. The length is sampled only while the FIFO is empty. A change while a block is in progress has no effect until the FIFO is empty again.
- R10: While the FIFO is empty and `cfg_bypass`=1, each input appears unchanged on `out_data` one cycle later and nothing is stored. `cfg_bypass` is ignored while a block is in progress.
- R11: All outputs except `tw_req` are registered. Every result appears exactly one cycle after the input step that produced it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample valid |
| in_data | input | W | Input residue, less than Q |
| cfg_log_len | input | LW | log2 of the FIFO length L |
| cfg_bypass | input | 1 | Pass-through request, honoured while empty |
| tw_data | input | W | Twiddle factor for the current compute step |
| tw_req | output | 1 | Stage is in the compute phase and needs a twiddle |
| out_valid | output | 1 | Output sample valid |
| out_data | output | W | Output residue |

## Verification
The bench goes after the edges between phases. It uses a length of one, where every phase is a single step, and the maximum length. It also runs blocks back to back, where the drain of one block overlaps the fill of the next. A stage that lost track of the count stored during the drain would skip or repeat a compute phase, and the outputs would then come out misaligned. The bench inserts input gaps in the fill and compute phases, which would expose a stage that advanced without `in_valid`, and gaps in the drain, which would expose one that stalled its drain. It also changes the length and raises bypass in the middle of a block. A stage that sampled them at any time other than when the FIFO is empty would emit values from a corrupted ring or pass raw inputs through.

// File: rtl/ntt_sdf_pkg.sv
package ntt_sdf_pkg;

  typedef enum logic [1:0] {
    PH_FILL  = 2'd0,
    PH_COMP  = 2'd1,
    PH_DRAIN = 2'd2
  } phase_e;

endpackage

// File: rtl/ntt_mod_arith.sv
// Combinational modular butterfly: forward sum and twiddled difference.
module ntt_mod_arith #(
  parameter int W = 13,
  parameter int Q = 7681
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] w_i,
  output logic [W-1:0] sum_o,
  output logic [W-1:0] dtw_o
);
  localparam int PW = 2 * W;
  localparam logic [W:0]    QX = (W+1)'(Q);
  localparam logic [PW-1:0] QP = PW'(Q);

  logic [W:0]    sum_raw;
  logic [W:0]    dif_raw;
  logic [PW-1:0] prod;
  logic [PW-1:0] rem;

  always_comb begin
    sum_raw = {1'b0, a_i} + {1'b0, b_i};
    if (sum_raw >= QX) sum_raw = sum_raw - QX;
    sum_o = sum_raw[W-1:0];
  end

  always_comb begin
    if (a_i >= b_i) dif_raw = {1'b0, a_i} - {1'b0, b_i};
    else            dif_raw = {1'b0, a_i} + QX - {1'b0, b_i};
  end

  assign prod  = PW'(dif_raw[W-1:0]) * PW'(w_i);
  assign rem   = prod % QP;
  assign dtw_o = rem[W-1:0];

endmodule

// File: rtl/ntt_fb_fifo.sv
// Ring-buffer feedback store whose active length is set by a power-of-two mask.
module ntt_fb_fifo #(
  parameter int W  = 13,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          pop,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] mask,
  output logic [W-1:0]  rdata,
  output logic [AW:0]   level
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [AW-1:0] wr_addr, rd_addr;

  assign wr_addr = wr_ptr & mask;
  assign rd_addr = rd_ptr & mask;
  assign rdata   = mem[rd_addr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_addr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_addr + AW'(1)) & mask;
      if (pop)  rd_ptr <= (rd_addr + AW'(1)) & mask;
      case ({push, pop})
        2'b10:   level <= level + (AW+1)'(1);
        2'b01:   level <= level - (AW+1)'(1);
        default: level <= level;
      endcase
    end
  end

endmodule

// File: rtl/ntt_sdf_ctrl.sv
// Phase sequencer: fill / compute / drain with overlapped refill.
module ntt_sdf_ctrl
  import ntt_sdf_pkg::*;
#(
  parameter int LOG_LMAX = 4,
  parameter int AW       = LOG_LMAX,
  parameter int LW       = $clog2(LOG_LMAX + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [LW-1:0] cfg_log_len,
  input  logic          cfg_bypass,
  output phase_e        phase,
  output logic          empty,
  output logic          pass,
  output logic          comp_fire,
  output logic          push,
  output logic          pop,
  output logic [AW-1:0] mask,
  output logic [LW-1:0] cur_log
);
  localparam int CW = AW + 1;
  localparam logic [LW-1:0] LMAX_L = LW'(LOG_LMAX);

  phase_e        phase_q, phase_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] pend_q, pend_d;
  logic [LW-1:0] log_q;
  logic [LW-1:0] log_clamp, log_eff;
  logic [CW-1:0] len, len_m1, cnt_inc, pend_inc;

  assign log_clamp = (cfg_log_len > LMAX_L) ? LMAX_L : cfg_log_len;
  assign empty     = (phase_q == PH_FILL) && (cnt_q == '0);
  assign log_eff   = empty ? log_clamp : log_q;
  assign len       = CW'(1) << log_eff;
  assign len_m1    = len - CW'(1);
  assign mask      = len_m1[AW-1:0];
  assign pass      = empty && cfg_bypass;
  assign cnt_inc   = cnt_q + CW'(1);
  assign pend_inc  = pend_q + CW'(in_valid);

  assign comp_fire = (phase_q == PH_COMP) && in_valid;
  assign push      = in_valid && !pass;
  assign pop       = comp_fire || (phase_q == PH_DRAIN);
  assign phase     = phase_q;
  assign cur_log   = log_q;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    pend_d  = pend_q;
    unique case (phase_q)
      PH_FILL: begin
        if (in_valid && !pass) begin
          if (cnt_inc == len) begin
            phase_d = PH_COMP;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_inc;
          end
        end
      end
      PH_COMP: begin
        if (in_valid) begin
          if (cnt_inc == len) begin
            phase_d = PH_DRAIN;
            cnt_d   = '0;
            pend_d  = '0;
          end else begin
            cnt_d = cnt_inc;
          end
        end
      end
      PH_DRAIN: begin
        pend_d = pend_inc;
        if (cnt_inc == len) begin
          if (pend_inc == len) begin
            phase_d = PH_COMP;
            cnt_d   = '0;
          end else begin
            phase_d = PH_FILL;
            cnt_d   = pend_inc;
          end
        end else begin
          cnt_d = cnt_inc;
        end
      end
      default: begin
        phase_d = PH_FILL;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_FILL;
      cnt_q   <= '0;
      pend_q  <= '0;
      log_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      pend_q  <= pend_d;
      log_q   <= log_eff;
    end
  end

endmodule

// File: rtl/ntt_sdf_stage.sv
// Top: one delay-feedback butterfly stage with registered output.
module ntt_sdf_stage
  import ntt_sdf_pkg::*;
#(
  parameter int W        = 13,
  parameter int Q        = 7681,
  parameter int LOG_LMAX = 4,
  parameter int LW       = $clog2(LOG_LMAX + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [W-1:0]  in_data,
  input  logic [LW-1:0] cfg_log_len,
  input  logic          cfg_bypass,
  input  logic [W-1:0]  tw_data,
  output logic          tw_req,
  output logic          out_valid,
  output logic [W-1:0]  out_data
);
  localparam int AW = LOG_LMAX;

  phase_e        phase;
  logic          fifo_empty, pass, comp_fire, push, pop;
  logic [AW-1:0] mask;
  logic [LW-1:0] cur_log;
  logic [AW:0]   fifo_level;
  logic [W-1:0]  fifo_rdata, fifo_wdata;
  logic [W-1:0]  bf_sum, bf_dtw;
  logic          ov_d;
  logic [W-1:0]  od_d;

  ntt_sdf_ctrl #(.LOG_LMAX(LOG_LMAX), .AW(AW), .LW(LW)) ctrl_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .cfg_log_len(cfg_log_len),
    .cfg_bypass(cfg_bypass), .phase(phase), .empty(fifo_empty), .pass(pass),
    .comp_fire(comp_fire), .push(push), .pop(pop), .mask(mask), .cur_log(cur_log)
  );

  ntt_fb_fifo #(.W(W), .AW(AW)) fifo_i (
    .clk(clk), .rst(rst), .push(push), .pop(pop), .wdata(fifo_wdata),
    .mask(mask), .rdata(fifo_rdata), .level(fifo_level)
  );

  ntt_mod_arith #(.W(W), .Q(Q)) arith_i (
    .a_i(fifo_rdata), .b_i(in_data), .w_i(tw_data),
    .sum_o(bf_sum), .dtw_o(bf_dtw)
  );

  assign fifo_wdata = (phase == PH_COMP) ? bf_dtw : in_data;
  assign tw_req     = (phase == PH_COMP);

  always_comb begin
    ov_d = 1'b0;
    od_d = fifo_rdata;
    if (pass) begin
      ov_d = in_valid;
      od_d = in_data;
    end else if (comp_fire) begin
      ov_d = 1'b1;
      od_d = bf_sum;
    end else if (phase == PH_DRAIN) begin
      ov_d = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= ov_d;
      out_data  <= od_d;
    end
  end

endmodule

// File: rtl/ntt_sdf_stage_chk.sv
module ntt_sdf_stage_chk #(
  parameter int W        = 13,
  parameter int Q        = 7681,
  parameter int LOG_LMAX = 4,
  parameter int LW       = $clog2(LOG_LMAX + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic [W-1:0]  in_data,
  input logic          cfg_bypass,
  input logic          tw_req,
  input logic          out_valid,
  input logic [W-1:0]  out_data,
  input logic          empty,
  input logic [1:0]    phase,
  input logic [LOG_LMAX:0] level,
  input logic [LW-1:0] cur_log
);
  assert_out_range_R3: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_data < W'(Q)));

  assert_bypass_pass_R10: assert property (@(posedge clk) disable iff (rst)
    (empty && cfg_bypass && in_valid) |=> (out_valid && out_data == $past(in_data)));

  assert_no_twreq_empty_R8: assert property (@(posedge clk) disable iff (rst)
    empty |-> !tw_req);

  assert_level_bound_R2: assert property (@(posedge clk) disable iff (rst)
    level <= ((LOG_LMAX+1)'(1) << cur_log));

  assert_len_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !empty |=> $stable(cur_log));

  assert_drain_emits_R5: assert property (@(posedge clk) disable iff (rst)
    (phase == 2'd2) |=> out_valid);

endmodule

bind ntt_sdf_stage ntt_sdf_stage_chk #(.W(W), .Q(Q), .LOG_LMAX(LOG_LMAX), .LW(LW)) chk_i (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
  .cfg_bypass(cfg_bypass), .tw_req(tw_req), .out_valid(out_valid),
  .out_data(out_data), .empty(fifo_empty), .phase(phase),
  .level(fifo_level), .cur_log(cur_log)
);

// File: tb/ntt_sdf_stage_tb_top.sv
module ntt_sdf_stage_tb_top;
  localparam int W        = 13;
  localparam int Q        = 7681;
  localparam int LOG_LMAX = 4;
  localparam int LW       = $clog2(LOG_LMAX + 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [W-1:0]  in_data = '0;
  logic [LW-1:0] cfg_log_len = '0;
  logic          cfg_bypass = 1'b0;
  logic [W-1:0]  tw_data = '0;
  logic          tw_req, out_valid;
  logic [W-1:0]  out_data;

  int  n_checks = 0;
  int  n_fail   = 0;
  bit  done     = 1'b0;

  always #2 clk = ~clk;

  ntt_sdf_stage #(.W(W), .Q(Q), .LOG_LMAX(LOG_LMAX)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .cfg_log_len(cfg_log_len), .cfg_bypass(cfg_bypass), .tw_data(tw_data),
    .tw_req(tw_req), .out_valid(out_valid), .out_data(out_data)
  );

  // Behavioural reference: queue plus phase bookkeeping
  int    fq[$];
  int    m_ph, m_cnt, m_pend, m_lg;
  bit    exp_v, exp_tw;
  int    exp_d;
  string exp_tag;

  always @(posedge clk) begin
    int lg_eff, len, a, b;
    bit is_empty;
    exp_v = 0; exp_d = 0; exp_tag = "R1";
    if (rst) begin
      fq.delete(); m_ph = 0; m_cnt = 0; m_pend = 0; m_lg = 0;
    end else begin
      is_empty = (fq.size() == 0) && (m_ph == 0);
      lg_eff = is_empty ? ((int'(cfg_log_len) > LOG_LMAX) ? LOG_LMAX : int'(cfg_log_len)) : m_lg;
      len = 1 << lg_eff;
      m_lg = lg_eff;
      b = int'(in_data);
      if (is_empty && cfg_bypass) begin
        exp_v = in_valid; exp_d = b; exp_tag = "R10 R11";
      end else if (m_ph == 0) begin
        exp_tag = in_valid ? "R2" : "R7";
        if (in_valid) begin
          fq.push_back(b); m_cnt++;
          if (m_cnt == len) begin m_ph = 1; m_cnt = 0; end
        end
      end else if (m_ph == 1) begin
        exp_tag = "R7";
        if (in_valid) begin
          a = fq.pop_front();
          exp_v = 1; exp_d = (a + b) % Q; exp_tag = "R3 R11";
          fq.push_back((((a - b + Q) % Q) * int'(tw_data)) % Q);
          m_cnt++;
          if (m_cnt == len) begin m_ph = 2; m_cnt = 0; m_pend = 0; end
        end
      end else begin
        exp_v = 1; exp_d = fq.pop_front(); exp_tag = "R4 R5 R6";
        if (in_valid) begin fq.push_back(b); m_pend++; end
        m_cnt++;
        if (m_cnt == len) begin
          if (m_pend == len) begin m_ph = 1; m_cnt = 0; end
          else begin m_ph = 0; m_cnt = m_pend; end
        end
      end
    end
    exp_tw = (m_ph == 1);
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, expv, $time);
    end
  endtask

  // Per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      chk(out_valid == exp_v, {exp_tag, " out_valid"}, int'(out_valid), int'(exp_v));
      if (exp_v) chk(int'(out_data) == exp_d, {exp_tag, " out_data"}, int'(out_data), exp_d);
      chk(tw_req == exp_tw, "R8 tw_req", int'(tw_req), int'(exp_tw));
    end
  end

  task automatic drive(input bit v, input int d, input int w);
    @(negedge clk);
    in_valid = v;
    in_data  = W'(v ? d : $urandom_range(Q - 1, 0));
    tw_data  = W'(w);
  endtask

  task automatic stream(input int n, input int gap_pct);
    for (int i = 0; i < n; i++) begin
      bit v;
      v = ($urandom_range(99, 0) >= gap_pct);
      drive(v, $urandom_range(Q - 1, 0), $urandom_range(Q - 1, 0));
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(0, 0, 0);
  endtask

  initial begin
    void'($urandom(32'd11));
    repeat (3) begin
      @(negedge clk);
      chk(out_valid == 1'b0 && tw_req == 1'b0, "R1 reset outputs", int'(out_valid), 0);
    end
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 after reset", int'(out_valid), 0);

    // R3 / R4 hand case with L = 1: a=5, b=3, w=2 -> sum 8, difference term 4
    cfg_log_len = LW'(0);
    drive(1, 5, 0);
    drive(1, 3, 2);
    drive(0, 0, 0);
    chk(out_valid && out_data == W'(8), "R3 hand sum", int'(out_data), 8);
    drive(0, 0, 0);
    chk(out_valid && out_data == W'(4), "R4 hand twiddled diff", int'(out_data), 4);
    idle(3);

    // R6: back-to-back blocks, L = 8
    cfg_log_len = LW'(3);
    stream(8 * 3 * 6, 0);
    idle(12);

    // R7: random gaps, L = 4
    cfg_log_len = LW'(2);
    stream(300, 35);
    idle(20);

    // R9: length change in the middle of a block has no effect
    cfg_log_len = LW'(3);
    drive(1, 100, 0); drive(1, 200, 0); drive(1, 300, 0);
    cfg_log_len = LW'(1);
    stream(40, 20);
    idle(20);

    // R9: out-of-range length clamps to the maximum, L = 16
    cfg_log_len = LW'(7);
    stream(16 * 3 * 3, 10);
    idle(40);

    // R10: bypass while empty, then bypass raised mid-block is ignored
    cfg_log_len = LW'(2);
    cfg_bypass = 1'b1;
    stream(20, 20);
    cfg_bypass = 1'b0;
    drive(1, 11, 0); drive(1, 22, 0);
    cfg_bypass = 1'b1;
    stream(30, 10);
    cfg_bypass = 1'b0;
    idle(20);

    // Mixed lengths including L = 1 streaming
    for (int k = 0; k <= LOG_LMAX; k++) begin
      cfg_log_len = LW'(k);
      stream((3 << k) * 4, 15);
      idle((1 << k) * 2 + 4);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

endmodule